// File: doc/BRIEF.md
# Dual Multi-Mode Timer

The block holds two independent timers, timer 0 and timer 1. Each timer has a low and a high 8-bit count register. The two timers share one mode register and one control register. Each timer is configured by a 4-bit nibble of the mode register. The control register holds a run bit and a sticky overflow flag for each timer.

Each timer runs in one of four counting structures:
- 13-bit counting, where five low bits act as a prescaler below the high byte.
- A full 16-bit counter.
- An 8-bit counter that reloads from the high byte.
- A split mode, in which timer 0 becomes two 8-bit counters.

In split mode, timer 0's high half uses timer 1's run bit and timer 1's overflow flag.

A timer advances by one on every clock cycle in which all of the following hold:
- The shared count strobe is high.
- The timer's run bit is set.
- Its gate bit is clear, or its external gate pin is high.

Software uses a synchronous write port and a combinational read port. Register addresses are:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Mode |
| 2 | Timer 0 low |
| 3 | Timer 0 high |
| 4 | Timer 1 low |
| 5 | Timer 1 high |

The two overflow flags also appear on output pins.

Top module: `tmr_pair`

## Requirements
- R1: Reset clears the control, mode and all four count registers to 0x00.
- R2: A write lands on the next clock. A read of any of addresses 0 to 5 shows the register's current value combinationally.
- R3: A timer holds its count registers unchanged in any cycle where the count strobe is low or its run bit is clear. Run bits: control bit 4 for timer 0, control bit 6 for timer 1.
- R4: Mode bit 3 is timer 0's gate bit and mode bit 7 is timer 1's gate bit. When a gate bit is set, that timer advances only while its gate pin is high (gate_pin[0] for timer 0, gate_pin[1] for timer 1). When a gate bit is clear, the gate pin has no effect.
- R5: Mode field 00 selects 13-bit counting:
  - Each step increments low bits 4:0 and clears low bits 7:5.
  - When bits 4:0 were 31, they wrap to 0 and the high byte increments.
  - A high-byte wrap from 0xFF sets the timer's flag.
- R6: Mode field 01 joins high:low into one 16-bit counter. A wrap from 0xFFFF to 0x0000 sets the timer's flag.
- R7: Mode field 10 counts the low byte only. A step taken from 0xFF loads the low byte from the high byte and sets the flag.
- R8: Mode field 11 on timer 0 splits it in two:
  - The low byte counts under run bit 4 and sets flag bit 5 on wrap.
  - The high byte counts under run bit 6, still subject to timer 0's gate condition, and sets flag bit 7 on wrap.
- R9: While timer 0 is split, timer 1 still counts in its other modes but never sets flag bit 7. Mode 11 on timer 1 holds it stopped.
- R10: The flags (control bits 5 and 7) are sticky until software writes the control register. A hardware set in the same cycle as a clearing write wins.
- R11: A write to a count register in the same cycle as an increment replaces the increment for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 ctrl, 1 mode, 2..5 counts) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| cnt_tick | input | 1 | Shared count-enable strobe |
| gate_pin | input | 2 | External gate inputs, bit i for timer i |
| ovf_flag | output | 2 | Overflow flags of timer 0 (bit 0) and timer 1 (bit 1) |

## Verification
Each mode is started just below its wrap point, so one stimulus exercises both the plain step and the carry path.

- **16-bit mode:** the start value 0xFFFE distinguishes a true 16-bit carry from two separate 8-bit counters.
- **13-bit mode:** a low byte with bits 7:5 set shows that the prescaler is five bits wide.
- **Reload mode:** a reload value of 0x80 distinguishes loading from the high byte from a wrap to zero.
- **Split mode:** with only timer 1's run bit set, the high half of timer 0 counts and flag 7 is set, which shows the borrowed run bit and flag.
- **Timer 1 during split:** timer 1 is driven through its own wrap, and flag 7 must stay clear.
- **Gate pins:** each pin is toggled with its gate bit set, to show counting is blocked and then resumed.
- **Same-cycle collisions:** a count write and a flag-clearing write are each issued in the same cycle as an increment, to check which one wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DW     = 8;   // count register width
    localparam int PRE_W  = 5;   // prescaler bits of the 13-bit mode
    localparam int NT     = 2;   // number of timers
    localparam int AW     = 3;   // register address width
    localparam int NIB    = 4;   // mode bits per timer
    localparam int CW     = 2 * DW;

    typedef enum logic [1:0] {
        MD_13    = 2'b00,
        MD_16    = 2'b01,
        MD_RLD   = 2'b10,
        MD_SPLIT = 2'b11
    } tmode_e;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } tcount_t;

    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_MODE = AW'(1);

    // control register bit positions
    localparam int RUN0 = 4;
    localparam int OVF0 = 5;
    localparam int RUN1 = 6;
    localparam int OVF1 = 7;

    // mode nibble bit positions
    localparam int GATE_BIT = 3;

    function automatic logic [AW-1:0] lo_addr(input int idx);
        return AW'(2 + 2 * idx);
    endfunction

    function automatic logic [AW-1:0] hi_addr(input int idx);
        return AW'(3 + 2 * idx);
    endfunction

endpackage

// File: rtl/tmr_enable.sv
module tmr_enable (
    input  logic tick,
    input  logic run,
    input  logic gate_en,
    input  logic pin,
    output logic go,
    output logic adv
);
    // go: strobe present and gate condition met; adv additionally needs run
    always_comb begin
        go  = tick && (!gate_en || pin);
        adv = go && run;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  tmode_e        mode,
    input  logic          adv,
    input  logic          adv_hi,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output tcount_t       cnt,
    output logic          ovf_lo,
    output logic          ovf_hi
);
    tcount_t         nxt;
    logic [CW-1:0]   wide_inc;
    logic [PRE_W-1:0] pre_inc;

    always_comb begin
        wide_inc = {cnt.hi, cnt.lo} + CW'(1);
        pre_inc  = cnt.lo[PRE_W-1:0] + PRE_W'(1);
    end

    always_comb begin
        nxt    = cnt;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            MD_13: begin
                if (adv) begin
                    nxt.lo = {{(DW-PRE_W){1'b0}}, pre_inc};
                    if (&cnt.lo[PRE_W-1:0]) begin
                        nxt.hi = cnt.hi + DW'(1);
                        ovf_lo = &cnt.hi;
                    end
                end
            end
            MD_16: begin
                if (adv) begin
                    {nxt.hi, nxt.lo} = wide_inc;
                    ovf_lo = &{cnt.hi, cnt.lo};
                end
            end
            MD_RLD: begin
                if (adv) begin
                    if (&cnt.lo) begin
                        nxt.lo = cnt.hi;
                        ovf_lo = 1'b1;
                    end else begin
                        nxt.lo = cnt.lo + DW'(1);
                    end
                end
            end
            MD_SPLIT: begin
                if (SPLIT_OK) begin
                    if (adv) begin
                        nxt.lo = cnt.lo + DW'(1);
                        ovf_lo = &cnt.lo;
                    end
                    if (adv_hi) begin
                        nxt.hi = cnt.hi + DW'(1);
                        ovf_hi = &cnt.hi;
                    end
                end
            end
            default: nxt = cnt;
        endcase
        if (wr_lo) nxt.lo = wdata;
        if (wr_hi) nxt.hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= nxt;
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          cnt_tick,
    input  logic [NT-1:0] gate_pin,
    output logic [NT-1:0] ovf_flag
);
    logic [DW-1:0] ctrl_q, ctrl_d;
    logic [DW-1:0] mode_q;
    logic [DW-1:0] lo_q [NT];
    logic [DW-1:0] hi_q [NT];
    logic [NT-1:0] go, adv, adv_hi, ovf_lo, ovf_hi;
    tmode_e        tmode [NT];
    logic          t0_split;
    logic          set0, set1;

    assign t0_split = (tmode[0] == MD_SPLIT);

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        tcount_t cnt;

        assign tmode[i] = tmode_e'(mode_q[NIB*i +: 2]);

        tmr_enable u_en (
            .tick    (cnt_tick),
            .run     (ctrl_q[RUN0 + 2*i]),
            .gate_en (mode_q[NIB*i + GATE_BIT]),
            .pin     (gate_pin[i]),
            .go      (go[i]),
            .adv     (adv[i])
        );

        if (i == 0) begin : g_hi_borrow
            assign adv_hi[i] = go[i] && ctrl_q[RUN1];
        end else begin : g_hi_none
            assign adv_hi[i] = 1'b0;
        end

        tmr_core #(.SPLIT_OK(i == 0)) u_core (
            .clk    (clk),
            .rst    (rst),
            .mode   (tmode[i]),
            .adv    (adv[i]),
            .adv_hi (adv_hi[i]),
            .wr_lo  (wr_en && (wr_addr == lo_addr(i))),
            .wr_hi  (wr_en && (wr_addr == hi_addr(i))),
            .wdata  (wr_data),
            .cnt    (cnt),
            .ovf_lo (ovf_lo[i]),
            .ovf_hi (ovf_hi[i])
        );

        assign lo_q[i] = cnt.lo;
        assign hi_q[i] = cnt.hi;
    end

    // flag sources: timer 1's flag goes to timer 0's high half while split
    always_comb begin
        set0 = ovf_lo[0];
        set1 = t0_split ? ovf_hi[0] : ovf_lo[1];
    end

    always_comb begin
        ctrl_d = (wr_en && wr_addr == A_CTRL) ? wr_data : ctrl_q;
        if (set0) ctrl_d[OVF0] = 1'b1;
        if (set1) ctrl_d[OVF1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_en && wr_addr == A_MODE) mode_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) rd_data = ctrl_q;
        if (rd_addr == A_MODE) rd_data = mode_q;
        for (int k = 0; k < NT; k++) begin
            if (rd_addr == lo_addr(k)) rd_data = lo_q[k];
            if (rd_addr == hi_addr(k)) rd_data = hi_q[k];
        end
    end

    assign ovf_flag = {ctrl_q[OVF1], ctrl_q[OVF0]};
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          cnt_tick,
    input logic [DW-1:0] ctrl_q,
    input logic [DW-1:0] mode_q,
    input logic [DW-1:0] lo0,
    input logic [DW-1:0] hi0,
    input logic [DW-1:0] lo1,
    input logic [DW-1:0] hi1
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && mode_q == '0 && lo0 == '0 && hi0 == '0 && lo1 == '0 && hi1 == '0));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick && !wr_en) |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1)));

    assert_flag0_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[5] && !(wr_en && wr_addr == '0)) |=> ctrl_q[5]);

    assert_flag1_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[7] && !(wr_en && wr_addr == '0)) |=> ctrl_q[7]);

    assert_inc16_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q[3:0] == 4'b0001 && ctrl_q[4] && cnt_tick && !wr_en && {hi0, lo0} != '1)
        |=> ({hi0, lo0} == $past({hi0, lo0}) + 1'b1));

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q[3:0] == 4'b0010 && ctrl_q[4] && cnt_tick && !wr_en && lo0 == '1)
        |=> (lo0 == $past(hi0) && ctrl_q[5]));

    assert_t1_split_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q[5:4] == 2'b11 && !wr_en) |=> ($stable(lo1) && $stable(hi1)));
endmodule

bind tmr_pair tmr_pair_chk #(.DW(tmr_pkg::DW), .AW(tmr_pkg::AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cnt_tick (cnt_tick),
    .ctrl_q   (ctrl_q),
    .mode_q   (mode_q),
    .lo0      (lo_q[0]),
    .hi0      (hi_q[0]),
    .lo1      (lo_q[1]),
    .hi1      (hi_q[1])
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 63;
    // entry: {kind[1:0], addr[2:0], data[7:0], req[3:0]}
    // kind 0 = write, 1 = tick for data cycles, 2 = check read of addr against data
    localparam logic [16:0] VEC [NV] = '{
        // R6: 16-bit mode from 0xFFFE
        {2'd0,3'd1,8'h01,4'd6}, {2'd0,3'd2,8'hFE,4'd6}, {2'd0,3'd3,8'hFF,4'd6},
        {2'd0,3'd0,8'h10,4'd6}, {2'd1,3'd0,8'h01,4'd6}, {2'd2,3'd2,8'hFF,4'd6},
        {2'd1,3'd0,8'h01,4'd6}, {2'd2,3'd2,8'h00,4'd6}, {2'd2,3'd0,8'h30,4'd6},
        // R10: sticky flag, software clear
        {2'd1,3'd0,8'h03,4'd10}, {2'd2,3'd2,8'h03,4'd10}, {2'd0,3'd0,8'h10,4'd10},
        {2'd2,3'd0,8'h10,4'd10},
        // R3: run cleared holds
        {2'd0,3'd0,8'h00,4'd3}, {2'd1,3'd0,8'h05,4'd3}, {2'd2,3'd2,8'h03,4'd3},
        // R7: auto-reload from 0x80
        {2'd0,3'd1,8'h02,4'd7}, {2'd0,3'd3,8'h80,4'd7}, {2'd0,3'd2,8'hFE,4'd7},
        {2'd0,3'd0,8'h10,4'd7}, {2'd1,3'd0,8'h02,4'd7}, {2'd2,3'd2,8'h80,4'd7},
        {2'd2,3'd0,8'h30,4'd7}, {2'd1,3'd0,8'h01,4'd7}, {2'd2,3'd2,8'h81,4'd7},
        // R2: mode readback
        {2'd2,3'd1,8'h02,4'd2},
        // R5: 13-bit mode
        {2'd0,3'd0,8'h00,4'd5}, {2'd0,3'd1,8'h00,4'd5}, {2'd0,3'd2,8'h1E,4'd5},
        {2'd0,3'd3,8'hFF,4'd5}, {2'd0,3'd0,8'h10,4'd5}, {2'd1,3'd0,8'h01,4'd5},
        {2'd1,3'd0,8'h01,4'd5}, {2'd2,3'd2,8'h00,4'd5}, {2'd2,3'd0,8'h30,4'd5},
        {2'd0,3'd0,8'h10,4'd5}, {2'd0,3'd2,8'hE5,4'd5}, {2'd1,3'd0,8'h01,4'd5},
        {2'd2,3'd2,8'h06,4'd5},
        // R8: split mode
        {2'd0,3'd0,8'h00,4'd8}, {2'd0,3'd1,8'h03,4'd8}, {2'd0,3'd2,8'hFF,4'd8},
        {2'd0,3'd3,8'hFF,4'd8}, {2'd0,3'd0,8'h40,4'd8}, {2'd1,3'd0,8'h01,4'd8},
        {2'd2,3'd3,8'h00,4'd8}, {2'd2,3'd0,8'hC0,4'd8}, {2'd0,3'd0,8'h10,4'd8},
        {2'd1,3'd0,8'h01,4'd8}, {2'd2,3'd2,8'h00,4'd8}, {2'd2,3'd0,8'h30,4'd8},
        // R9: timer 1 under split, then timer 1 split holds
        {2'd0,3'd0,8'h00,4'd9}, {2'd0,3'd1,8'h13,4'd9}, {2'd0,3'd4,8'hFF,4'd9},
        {2'd0,3'd5,8'hFF,4'd9}, {2'd0,3'd0,8'h40,4'd9}, {2'd1,3'd0,8'h01,4'd9},
        {2'd2,3'd4,8'h00,4'd9}, {2'd2,3'd3,8'h01,4'd9}, {2'd2,3'd0,8'h40,4'd9},
        {2'd0,3'd1,8'h30,4'd9}, {2'd1,3'd0,8'h03,4'd9}, {2'd2,3'd4,8'h00,4'd9}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt_tick = 1'b0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ovf_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    tmr_pair u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_tick(cnt_tick),
        .gate_pin(gate_pin), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [7:0] exp, input int req);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL R%0d addr %0d actual %02h expected %02h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of all six registers
        for (int a = 0; a < 6; a++) chk(3'(a), 8'h00, 1);
        // R1: flag pins clear
        checks++;
        if (ovf_flag !== 2'b00) begin
            failures++;
            $display("FAIL R1 ovf_flag actual %b expected 00", ovf_flag);
        end

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][16:15])
                2'd0: wr(VEC[i][14:12], VEC[i][11:4]);
                2'd1: run_ticks(int'(VEC[i][11:4]));
                default: chk(VEC[i][14:12], VEC[i][11:4], int'(VEC[i][3:0]));
            endcase
        end

        // R4: timer 0 gate bit, pin low blocks, pin high allows
        wr(3'd0, 8'h00); wr(3'd1, 8'h08); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd0, 8'h10);
        gate_pin = 2'b00;
        run_ticks(4);
        chk(3'd2, 8'h00, 4);
        gate_pin = 2'b01;
        run_ticks(2);
        chk(3'd2, 8'h02, 4);
        // R4: timer 1 gate bit with 16-bit mode
        wr(3'd0, 8'h00); wr(3'd1, 8'h90); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd0, 8'h40);
        gate_pin = 2'b00;
        run_ticks(2);
        chk(3'd4, 8'h00, 4);
        gate_pin = 2'b10;
        run_ticks(3);
        chk(3'd4, 8'h03, 4);
        gate_pin = 2'b00;

        // R11: count write in the same cycle as an increment
        wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h00);
        wr(3'd0, 8'h10);
        @(negedge clk);
        cnt_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h55;
        @(negedge clk);
        cnt_tick = 1'b0; wr_en = 1'b0;
        chk(3'd2, 8'h55, 11);
        chk(3'd3, 8'h00, 11);

        // R10: hardware set beats a clearing control write in the same cycle
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        @(negedge clk);
        cnt_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h10;
        @(negedge clk);
        cnt_tick = 1'b0; wr_en = 1'b0;
        chk(3'd0, 8'h30, 10);
        chk(3'd2, 8'h00, 6);
        checks++;
        if (ovf_flag !== 2'b01) begin
            failures++;
            $display("FAIL R10 ovf_flag actual %b expected 01", ovf_flag);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule